// File: doc/BRIEF.md
# Compare Timer with Prescaler

A 32-bit up-counting timer that serves a processor both as a free-running time base and as a one-shot event source. A clock-divider stage turns the system clock into count ticks, the counter wraps to zero after a programmable top value, and a single compare channel raises a sticky flag when the count reaches a programmed value. A level interrupt follows that flag while it is enabled.

Software reaches every register through a simple synchronous bus made of address, write data, write strobe and read data. Writes take effect at the clock edge where the strobe is high. Read data is registered, so it appears one cycle after the address and shows the state from before that edge. The whole block runs on one clock and uses a synchronous active-high reset.

To program a one-shot event, software reads the count, adds a delta, writes the sum to the compare value, and waits for the interrupt. It then clears the flag by writing one to the status register.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, the control, count, status, channel control and compare value registers read 0, the top value reads 0xFFFFFFFF, and `irq` is low.
- R2: Control bits 4:3 form the run field. When it is 1, the count advances by one on each divider tick. Any other value holds the count, apart from a tick that falls on the very edge that writes the new value.
- R3: Control bits 2:0 hold a divide code P, and a tick occurs once every 2^P clocks. A write to the control register restarts the divider, so with P=3 the first increment lands on the 8th edge after the write and not on the 7th.
- R4: At a tick where the count equals the top value (offset 0x18), the count goes to 0 instead of incrementing. With the reset top value the full 32-bit range is used.
- R5: Any write to the count offset (0x14) clears the count to 0, whatever the write data.
- R6: Channel control (0x20) holds the interrupt enable in bit 6 and the channel mode in bits 5:2. Mode 0x4 is software compare. When the mode is nonzero and a tick moves the count onto the compare value (0x24), status bit 0 (0x1C) is set. When the mode is 0 the flag is never set.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a match and a clearing write fall on the same edge, the flag stays set.
- R8: `irq` is active-high and level-sensitive. It is high exactly while the flag is set and the interrupt enable is 1.
- R9: Offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 read back control {run, divide code}, the count, the top value, the status, the channel control and the compare value. Any other offset reads 0. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt from the compare channel |

## Verification
A divider that drifts by even one clock shows up as a count that is off by one when the counter is stopped at a tick boundary. The next read of the count exposes it. A wrong wrap or a clear that is not applied shows up at the very next read of the count. A lost flag, or a flag set where it should not be, shows on `irq` and in the status read within a cycle of the edge concerned. The same-edge race between a match and a clearing write is visible at the first status read after it.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int unsigned OFS_CTRL   = 32'h10;
  localparam int unsigned OFS_COUNT  = 32'h14;
  localparam int unsigned OFS_TOP    = 32'h18;
  localparam int unsigned OFS_STATUS = 32'h1C;
  localparam int unsigned OFS_CHCTL  = 32'h20;
  localparam int unsigned OFS_CHVAL  = 32'h24;
  localparam logic [1:0]  RUN_MODE_ON = 2'd1;
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           restart,
  input  logic [PSW-1:0] ps,
  output logic           tick
);
  localparam int DW = (1 << PSW) - 1;

  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  // low P bits all ones marks the last clock of a 2^P period
  always_comb mask = ~({DW{1'b1}} << ps);

  assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next,
  output logic          step
);
  logic [CW-1:0] cnt_q;

  always_comb cnt_next = (cnt_q == top) ? '0 : cnt_q + 1'b1;
  assign step = tick && !clr;
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_next;
  end
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int CW = 32,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctl,
  input  logic          wr_val,
  input  logic          wr_sts,
  input  logic [MW:0]   ctl_wdata,
  input  logic [CW-1:0] val_wdata,
  input  logic          sts_wdata,
  input  logic          step,
  input  logic [CW-1:0] cnt_next,
  output logic [MW-1:0] mode,
  output logic          ie,
  output logic [CW-1:0] cmp_val,
  output logic          flag,
  output logic          irq
);
  logic [MW-1:0] mode_q;
  logic          ie_q;
  logic [CW-1:0] val_q;
  logic          flag_q;
  logic          match;

  assign match = step && (mode_q != '0) && (cnt_next == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ie_q   <= 1'b0;
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ie_q   <= ctl_wdata[MW];
        mode_q <= ctl_wdata[MW-1:0];
      end
      if (wr_val) val_q <= val_wdata;
      if (match)                       flag_q <= 1'b1;
      else if (wr_sts && sts_wdata)    flag_q <= 1'b0;
    end
  end

  assign mode    = mode_q;
  assign ie      = ie_q;
  assign cmp_val = val_q;
  assign flag    = flag_q;
  assign irq     = flag_q && ie_q;
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer #(
  parameter int AW  = 8,
  parameter int CW  = 32,
  parameter int PSW = 3,
  parameter int MW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  import tct_pkg::*;

  localparam int RMW    = 2;
  localparam int CTL_LO = PSW;
  localparam int IE_BIT = MW + 2;

  logic [PSW-1:0] ps_q;
  logic [RMW-1:0] rmode_q;
  logic [CW-1:0]  top_q;
  logic [CW-1:0]  rdata_q;
  logic           run, tick, cnt_clr, step;
  logic           wr_ctrl, wr_chctl, wr_chval, wr_sts;
  logic [CW-1:0]  cnt_q, cnt_next, ch_val;
  logic [MW-1:0]  ch_mode;
  logic           ch_ie, flag;

  assign wr_ctrl  = bus_we && (bus_addr == AW'(OFS_CTRL));
  assign cnt_clr  = bus_we && (bus_addr == AW'(OFS_COUNT));
  assign wr_sts   = bus_we && (bus_addr == AW'(OFS_STATUS));
  assign wr_chctl = bus_we && (bus_addr == AW'(OFS_CHCTL));
  assign wr_chval = bus_we && (bus_addr == AW'(OFS_CHVAL));
  assign run      = (rmode_q == RUN_MODE_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q    <= '0;
      rmode_q <= '0;
      top_q   <= '1;
    end else begin
      if (wr_ctrl) begin
        ps_q    <= bus_wdata[PSW-1:0];
        rmode_q <= bus_wdata[CTL_LO +: RMW];
      end
      if (bus_we && (bus_addr == AW'(OFS_TOP))) top_q <= bus_wdata;
    end
  end

  tct_prescaler #(.PSW(PSW)) u_div (
    .clk(clk), .rst(rst), .run(run), .restart(wr_ctrl), .ps(ps_q), .tick(tick)
  );

  tct_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(cnt_clr), .top(top_q),
    .cnt(cnt_q), .cnt_next(cnt_next), .step(step)
  );

  tct_channel #(.CW(CW), .MW(MW)) u_ch (
    .clk(clk), .rst(rst), .wr_ctl(wr_chctl), .wr_val(wr_chval), .wr_sts(wr_sts),
    .ctl_wdata(bus_wdata[IE_BIT:2]), .val_wdata(bus_wdata), .sts_wdata(bus_wdata[0]),
    .step(step), .cnt_next(cnt_next), .mode(ch_mode), .ie(ch_ie),
    .cmp_val(ch_val), .flag(flag), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (int'(bus_addr))
        OFS_CTRL:   rdata_q <= {{(CW-RMW-PSW){1'b0}}, rmode_q, ps_q};
        OFS_COUNT:  rdata_q <= cnt_q;
        OFS_TOP:    rdata_q <= top_q;
        OFS_STATUS: rdata_q <= {{(CW-1){1'b0}}, flag};
        OFS_CHCTL:  rdata_q <= {{(CW-MW-3){1'b0}}, ch_ie, ch_mode, 2'b00};
        OFS_CHVAL:  rdata_q <= ch_val;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int CW  = 32,
  parameter int PSW = 3,
  parameter int MW  = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          run,
  input logic          cnt_clr,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] top,
  input logic          flag,
  input logic [MW-1:0] ch_mode,
  input logic          ch_ie,
  input logic          irq,
  input logic [PSW-1:0] ps
);
  a_r5_count_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt == '0));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_clr) |=> $stable(cnt));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_clr && (cnt == top)) |=> (cnt == '0));

  a_r3_div_one: assert property (@(posedge clk) disable iff (rst)
    (run && (ps == '0)) |-> tick);

  a_r3_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  a_r6_mode_off: assert property (@(posedge clk) disable iff (rst)
    ((ch_mode == '0) && !flag) |=> !flag);

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ch_ie && flag));
endmodule

bind tick_compare_timer tct_checker #(.CW(CW), .PSW(PSW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run), .cnt_clr(cnt_clr),
  .cnt(cnt_q), .top(top_q), .flag(flag), .ch_mode(ch_mode), .ch_ie(ch_ie),
  .irq(irq), .ps(ps_q)
);

// File: tb/tick_compare_timer_tb.sv
module tick_compare_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OPW = 2'd0, OPR = 2'd1, OPD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        eirq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 55;
  localparam vec_t VEC [NV] = '{
    '{OPW, 8'h18, 32'd5,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h24, 32'd3,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h20, 32'h50,   32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h08,   32'd0, 1'b0, 4'd0},
    '{OPD, 8'h00, 32'd2,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd3, 1'b1, 4'd2},  // R2 one per tick
    '{OPR, 8'h1C, 32'd0,    32'd1, 1'b1, 4'd6},  // R6 match sets flag
    '{OPW, 8'h1C, 32'd0,    32'd0, 1'b0, 4'd0},
    '{OPR, 8'h1C, 32'd0,    32'd1, 1'b1, 4'd7},  // R7 write 0 ignored
    '{OPW, 8'h1C, 32'd1,    32'd0, 1'b0, 4'd0},
    '{OPR, 8'h1C, 32'd0,    32'd0, 1'b0, 4'd7},  // R7 write 1 clears
    '{OPW, 8'h10, 32'h08,   32'd0, 1'b0, 4'd0},
    '{OPD, 8'h00, 32'd2,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd0, 1'b0, 4'd4},  // R4 wrap after top
    '{OPR, 8'h1C, 32'd0,    32'd0, 1'b0, 4'd6},  // R6 no match off value
    '{OPW, 8'h10, 32'h08,   32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd1, 1'b0, 4'd2},  // R2 tick on stop edge
    '{OPW, 8'h14, 32'hFFFF, 32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd0, 1'b0, 4'd5},  // R5 clear ignores data
    '{OPW, 8'h10, 32'h0B,   32'd0, 1'b0, 4'd0},
    '{OPD, 8'h00, 32'd6,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd0, 1'b0, 4'd3},  // R3 no tick by 7th edge
    '{OPW, 8'h10, 32'h0B,   32'd0, 1'b0, 4'd0},
    '{OPD, 8'h00, 32'd7,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd1, 1'b0, 4'd3},  // R3 tick on 8th edge
    '{OPW, 8'h20, 32'h40,   32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h08,   32'd0, 1'b0, 4'd0},
    '{OPD, 8'h00, 32'd1,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd3, 1'b0, 4'd2},
    '{OPR, 8'h1C, 32'd0,    32'd0, 1'b0, 4'd6},  // R6 mode 0 never sets
    '{OPW, 8'h14, 32'd0,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h24, 32'd2,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h20, 32'h50,   32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h08,   32'd0, 1'b0, 4'd0},
    '{OPW, 8'h1C, 32'd1,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h1C, 32'd1,    32'd0, 1'b0, 4'd0},
    '{OPW, 8'h10, 32'h00,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h1C, 32'd0,    32'd1, 1'b1, 4'd7},  // R7 match beats clear
    '{OPW, 8'h20, 32'h10,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h1C, 32'd0,    32'd1, 1'b0, 4'd8},  // R8 enable gates irq
    '{OPR, 8'h20, 32'd0,    32'h10, 1'b0, 4'd9}, // R9 readback
    '{OPR, 8'h18, 32'd0,    32'd5, 1'b0, 4'd9},
    '{OPR, 8'h24, 32'd0,    32'd2, 1'b0, 4'd9},
    '{OPR, 8'h10, 32'd0,    32'd0, 1'b0, 4'd9},
    '{OPR, 8'h40, 32'd0,    32'd0, 1'b0, 4'd9},  // R9 unmapped reads 0
    '{OPW, 8'h10, 32'h13,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h10, 32'd0,    32'h13, 1'b0, 4'd9},
    '{OPD, 8'h00, 32'd20,   32'd0, 1'b0, 4'd0},
    '{OPR, 8'h14, 32'd0,    32'd3, 1'b0, 4'd2}   // R2 run field 2 holds
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_compare_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e,
                        input logic ei, input string tag);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (bus_rdata !== e || irq !== ei) begin
      n_bad++;
      $display("FAIL %s addr %h: rdata %h irq %b, expected %h irq %b",
               tag, a, bus_rdata, irq, e, ei);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk(8'h10, 32'd0, 1'b0, "R1");
    rd_chk(8'h14, 32'd0, 1'b0, "R1");
    rd_chk(8'h18, 32'hFFFF_FFFF, 1'b0, "R1");
    rd_chk(8'h1C, 32'd0, 1'b0, "R1");
    rd_chk(8'h20, 32'd0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OPW: wr(VEC[i].addr, VEC[i].data);
        OPD: repeat (VEC[i].data) @(negedge clk);
        default: rd_chk(VEC[i].addr, VEC[i].exp, VEC[i].eirq,
                        $sformatf("R%0d", VEC[i].req));
      endcase
    end

    // R1 reset while running with a pending flag
    wr(8'h20, 32'h50);
    rd_chk(8'h1C, 32'd1, 1'b1, "R8");
    wr(8'h10, 32'h08);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    rd_chk(8'h14, 32'd0, 1'b0, "R1");
    rd_chk(8'h1C, 32'd0, 1'b0, "R1");
    rd_chk(8'h18, 32'hFFFF_FFFF, 1'b0, "R1");

    // R4 full-range top: no early wrap
    wr(8'h10, 32'h08);
    repeat (9) @(negedge clk);
    wr(8'h10, 32'h00);
    rd_chk(8'h14, 32'd10, 1'b0, "R4");
    report();
  end
endmodule